// File: doc/BRIEF.md
# Scalable System Time Counter

This block keeps a 64-bit system time count that advances on an external tick strobe. A 32-bit control register, reached over a simple single-cycle memory-mapped bus, turns counting on and off, decides whether a debug halt input may freeze the count, and chooses between a plain step of one and a programmable fixed-point step. It also holds a frequency-mode request that picks one entry of a small constant table supplied at the block's pins.

The step is held in 8.24 fixed point. With scaling off every tick adds exactly 1.0. With scaling on every tick adds the programmed scale value, and the 24-bit fractional part builds up in an internal accumulator whose carry feeds the integer count. Software can write the count as two 32-bit halves. Each such write clears the accumulated fraction. The scale-enable choice is locked while the counter runs. A frequency request that names a missing or zero table entry is dropped, and the entry already in effect stays selected.

Top module: `sys_counter`

## Requirements
- R1: After reset the control register reads 0, the count and the hidden fraction are 0, the scale register reads 0x01000000 (1.0), and frequency entry 0 is selected (freqIdx 0, freqSel equal to table entry 0).
- R2: The control register sits at offset 0x000. Bit 0 is enable, bit 1 is halt-on-debug, bit 2 is scale enable, and bits 17:8 carry the frequency index. All other bits read 0, and writes to them are ignored.
- R3: While enable is 0 the count never changes on a tick. While enable is 1, with scaling off, each tick adds exactly 1 to the count, and a carry out of bit 31 reaches bit 32.
- R4: When halt-on-debug is 1 and haltReq is high, ticks leave the count unchanged. When halt-on-debug is 0, haltReq has no effect.
- R5: The scale register at offset 0x010 holds an 8.24 step. With scale enable 1, each tick adds that step to the 64-bit count plus the 24-bit fraction, and the count shows the integer part.
- R6: A control write made while enable is currently 1 leaves scale enable unchanged, even if the same write clears enable. While enable is 0, scale enable takes the written value.
- R7: The count low word is at 0x008 and the high word at 0x00C, and both can be read and written. A write to either half clears the fraction to 0. A write takes precedence over a tick in the same cycle.
- R8: A written frequency index below NUM_MODES whose table entry is nonzero becomes the entry in effect. Any other index is ignored. The control register's index field, freqIdx and freqSel always show the entry in effect.
- R9: A bus write shows on the read data and the outputs from the next cycle on. Read data depends combinationally on busAddr. The count changes one cycle after a tick is sampled. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr |
| tick | input | 1 | Counter tick strobe |
| haltReq | input | 1 | Debug halt request |
| freqTable | input | NUM_MODES*32 | Constant frequency table, entry i at bits 32*i+31:32*i |
| count | output | 64 | Current integer count |
| freqSel | output | 32 | Table value of the entry in effect |
| freqIdx | output | IDX_W | Index of the entry in effect |

## Verification
Register writes are sampled on one rising edge and show up after it. Read data follows busAddr with no register in between. The count and the fraction move one edge after a sampled tick. The bench drives every stimulus on a falling edge, lets exactly one rising edge pass for each write or tick cycle, and compares the outputs on the next falling edge. Fraction behaviour is observed only through the count, so the step sequences are chosen so that a fraction that was kept, lost or left uncleared produces a different integer count.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  localparam int OFF_CTRL    = 'h000;
  localparam int OFF_CNT_LO  = 'h008;
  localparam int OFF_CNT_HI  = 'h00C;
  localparam int OFF_SCALE   = 'h010;
  localparam int FRAC_W      = 24;
  localparam int REQ_W       = 10;
  localparam logic [31:0] UNIT_STEP = 32'h0100_0000;

  typedef struct packed {
    logic        wrLo;
    logic        wrHi;
    logic        advance;
    logic [31:0] step;
    logic [31:0] data;
  } ctr_strobe_t;
endpackage

// File: rtl/sysctr_ctrl.sv
module sysctr_ctrl
  import sysctr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_MODES = 8,
  localparam int IDX_W    = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic                   busWrEn,
  input  logic [31:0]            busWrData,
  output logic [31:0]            busRdData,
  input  logic                   tick,
  input  logic                   haltReq,
  input  logic [NUM_MODES*32-1:0] freqTable,
  input  logic [63:0]            countIn,
  output ctr_strobe_t            strobe,
  output logic [31:0]            freqSel,
  output logic [IDX_W-1:0]       freqIdx
);
  localparam logic [REQ_W-1:0] MODES_L = REQ_W'(NUM_MODES);

  logic        enBit, hdbgBit, scenBit;
  logic [31:0] scaleReg;
  logic [31:0] modeTbl [NUM_MODES];

  for (genvar i = 0; i < NUM_MODES; i++) begin : g_tbl
    assign modeTbl[i] = freqTable[i*32 +: 32];
  end

  logic selCtrl, selLo, selHi, selScale;
  assign selCtrl  = busAddr == ADDR_W'(OFF_CTRL);
  assign selLo    = busAddr == ADDR_W'(OFF_CNT_LO);
  assign selHi    = busAddr == ADDR_W'(OFF_CNT_HI);
  assign selScale = busAddr == ADDR_W'(OFF_SCALE);

  logic [REQ_W-1:0] reqIdx;
  logic             reqOk;
  assign reqIdx = busWrData[17:8];
  always_comb begin
    reqOk = 1'b0;
    if (reqIdx < MODES_L)
      reqOk = modeTbl[reqIdx[IDX_W-1:0]] != 32'd0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit    <= 1'b0;
      hdbgBit  <= 1'b0;
      scenBit  <= 1'b0;
      freqIdx  <= '0;
      scaleReg <= UNIT_STEP;
    end else if (busWrEn) begin
      if (selCtrl) begin
        enBit   <= busWrData[0];
        hdbgBit <= busWrData[1];
        if (!enBit) scenBit <= busWrData[2];
        if (reqOk) freqIdx <= reqIdx[IDX_W-1:0];
      end
      if (selScale) scaleReg <= busWrData;
    end
  end

  assign freqSel = modeTbl[freqIdx];

  always_comb begin
    strobe.wrLo    = busWrEn && selLo;
    strobe.wrHi    = busWrEn && selHi;
    strobe.data    = busWrData;
    strobe.step    = scenBit ? scaleReg : UNIT_STEP;
    strobe.advance = tick && enBit && !(hdbgBit && haltReq);
  end

  always_comb begin
    busRdData = '0;
    if (selCtrl)  busRdData = {14'd0, REQ_W'(freqIdx), 5'd0, scenBit, hdbgBit, enBit};
    if (selLo)    busRdData = countIn[31:0];
    if (selHi)    busRdData = countIn[63:32];
    if (selScale) busRdData = scaleReg;
  end

  // R6: scale enable frozen while counting
  p_scen_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    enBit |=> $stable(scenBit));
  // R8: entry in effect only moves on a control write
  p_freq_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && selCtrl) |=> $stable(freqIdx));
  // R8: entry in effect is always implemented
  p_freq_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    32'(freqIdx) < NUM_MODES);
  // R4: halted counter gets no advance strobe
  p_halt_stops_r4: assert property (@(posedge clk) disable iff (!rstN)
    (hdbgBit && haltReq) |-> !strobe.advance);
endmodule

// File: rtl/sysctr_datapath.sv
module sysctr_datapath
  import sysctr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctr_strobe_t strobe,
  output logic [63:0] count
);
  logic [FRAC_W-1:0] frac;
  logic [FRAC_W:0]   fracSum;
  logic [63:0]       intAdd;

  assign fracSum = {1'b0, frac} + {1'b0, strobe.step[FRAC_W-1:0]};
  assign intAdd  = 64'(strobe.step[31:FRAC_W]) + 64'(fracSum[FRAC_W]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      frac  <= '0;
    end else if (strobe.wrLo || strobe.wrHi) begin
      if (strobe.wrLo) count[31:0]  <= strobe.data;
      if (strobe.wrHi) count[63:32] <= strobe.data;
      frac <= '0;
    end else if (strobe.advance) begin
      count <= count + intAdd;
      frac  <= fracSum[FRAC_W-1:0];
    end
  end

  // R3: idle cycles keep count and fraction
  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.advance || strobe.wrLo || strobe.wrHi) |=> ($stable(count) && $stable(frac)));
  // R7: count write clears the fraction
  p_write_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrLo || strobe.wrHi) |=> frac == '0);
  // R5: a step of at least 1.0 always moves the count
  p_step_moves_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.wrLo && !strobe.wrHi && strobe.step[31:FRAC_W] != 8'd0)
      |=> count != $past(count));
endmodule

// File: rtl/sys_counter.sv
module sys_counter
  import sysctr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_MODES = 8,
  localparam int IDX_W    = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrEn,
  input  logic [31:0]             busWrData,
  output logic [31:0]             busRdData,
  input  logic                    tick,
  input  logic                    haltReq,
  input  logic [NUM_MODES*32-1:0] freqTable,
  output logic [63:0]             count,
  output logic [31:0]             freqSel,
  output logic [IDX_W-1:0]        freqIdx
);
  ctr_strobe_t strobe;

  sysctr_ctrl #(.ADDR_W(ADDR_W), .NUM_MODES(NUM_MODES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .tick(tick),
    .haltReq(haltReq), .freqTable(freqTable), .countIn(count),
    .strobe(strobe), .freqSel(freqSel), .freqIdx(freqIdx)
  );

  sysctr_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(count)
  );
endmodule

// File: tb/tb_sys_counter.sv
`timescale 1ns/1ps
module tb_sys_counter;
  localparam int NM = 8;
  logic clk = 0, rstN = 0, busWrEn = 0, tick = 0, haltReq = 0;
  logic [7:0] busAddr = 0;
  logic [31:0] busWrData = 0, busRdData, freqSel;
  logic [NM*32-1:0] freqTable;
  logic [63:0] count;
  logic [2:0] freqIdx;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  for (genvar i = 0; i < NM; i++) begin : g_t
    assign freqTable[i*32 +: 32] = (i == 3 || i == 5) ? 32'd0 : 32'(1000 * (i + 1));
  end

  sys_counter dut (.*);

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic rdChk(string tag, logic [7:0] a, logic [31:0] exp);
    busAddr = a; #1;
    chk(tag, 64'(busRdData), 64'(exp));
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic setCount(logic [63:0] v);
    wr(8'h08, v[31:0]); wr(8'h0C, v[63:32]);
  endtask

  localparam int NV = 9;
  localparam logic [7:0]  VA [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h10, 8'h08, 8'h0C, 8'h00};
  localparam logic [31:0] VD [NV] = '{32'hFFFC_FFF8, 32'h0000_0206, 32'h0000_0306, 32'h0000_0806,
                                      32'h0000_0704, 32'h0180_0000, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0};
  localparam logic [31:0] VE [NV] = '{32'h0, 32'h0000_0206, 32'h0000_0206, 32'h0000_0206,
                                      32'h0000_0704, 32'h0180_0000, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rdChk("R1 ctrl", 8'h00, 32'h0);
    rdChk("R1 scale", 8'h10, 32'h0100_0000);
    chk("R1 count", count, 64'h0);
    chk("R1 freqIdx", 64'(freqIdx), 64'h0);
    chk("R1 freqSel", 64'(freqSel), 64'd1000);
    rdChk("R9 unmapped", 8'h04, 32'h0);

    // R2 R8 R9 register vectors
    for (int i = 0; i < NV; i++) begin
      wr(VA[i], VD[i]);
      rdChk($sformatf("R2/R8 vec%0d", i), VA[i], VE[i]);
    end

    // R8 frequency selection at the outputs
    wr(8'h00, 32'h0000_0200);
    chk("R8 sel2", 64'(freqSel), 64'd3000);
    wr(8'h00, 32'h0000_0500);
    chk("R8 zero entry idx", 64'(freqIdx), 64'd2);
    chk("R8 zero entry sel", 64'(freqSel), 64'd3000);
    wr(8'h00, 32'h0000_0900);
    chk("R8 unimpl idx", 64'(freqIdx), 64'd2);
    wr(8'h00, 32'h0000_0700);
    chk("R8 sel7", 64'(freqSel), 64'd8000);

    // R3 enable
    wr(8'h00, 32'h0);
    setCount(64'd0);
    ticks(3);
    chk("R3 disabled", count, 64'd0);
    wr(8'h00, 32'h1);
    ticks(5);
    chk("R3 enabled", count, 64'd5);
    setCount(64'h0000_0000_FFFF_FFFF);
    ticks(1);
    chk("R3 carry", count, 64'h0000_0001_0000_0000);

    // R4 halt on debug
    setCount(64'd0);
    haltReq = 1;
    wr(8'h00, 32'h3);
    ticks(4);
    chk("R4 halted", count, 64'd0);
    wr(8'h00, 32'h1);
    ticks(2);
    chk("R4 ignored", count, 64'd2);
    haltReq = 0;

    // R6 scale enable lock
    wr(8'h00, 32'h5);
    rdChk("R6 locked", 8'h00, 32'h1);
    wr(8'h00, 32'h4);
    rdChk("R6 locked on disable", 8'h00, 32'h0);
    wr(8'h00, 32'h4);
    rdChk("R6 free", 8'h00, 32'h4);

    // R5 scaling 1.5
    wr(8'h10, 32'h0180_0000);
    setCount(64'd0);
    wr(8'h00, 32'h5);
    ticks(1);
    chk("R5 1x1.5", count, 64'd1);
    ticks(2);
    chk("R5 3x1.5", count, 64'd4);
    ticks(1);
    chk("R5 4x1.5", count, 64'd6);
    wr(8'h00, 32'h4);
    wr(8'h10, 32'h0040_0000);
    setCount(64'd0);
    wr(8'h00, 32'h5);
    ticks(3);
    chk("R5 3x0.25", count, 64'd0);
    ticks(1);
    chk("R5 4x0.25", count, 64'd1);

    // R7 fraction cleared by count write, write beats tick
    wr(8'h00, 32'h4);
    wr(8'h10, 32'h0180_0000);
    setCount(64'd0);
    wr(8'h00, 32'h5);
    ticks(1);
    wr(8'h08, 32'd10);
    ticks(1);
    chk("R7 frac cleared", count, 64'd11);
    @(negedge clk); tick = 1; busAddr = 8'h08; busWrData = 32'd100; busWrEn = 1;
    @(negedge clk); tick = 0; busWrEn = 0;
    chk("R7 write wins", count, 64'd100);
    wr(8'h0C, 32'h0000_00AB);
    rdChk("R7 hi read", 8'h0C, 32'h0000_00AB);
    rdChk("R7 lo read", 8'h08, 32'd100);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule